// File: doc/BRIEF.md
# Paged register address translator

This block sits between a serial command decoder and a register file. Each command carries only a 5-bit register address, but the register bus inside the device is 12 bits wide. The block keeps a 7-bit page register and places it above the command address to form the full bus address. It also passes the read and write strobes through to the register file, and it gates them.

One command slot, the top address 31, is reserved on every page for the page register itself. A write there loads the page from the low bits of the write data, whatever page is currently selected. That write never reaches the register file. The page register cannot be read back: a read of slot 31 returns zero.

Only the first `USED_PAGES` pages hold registers. On any other page, every access is dropped and every read returns zero.

Top module: `paged_reg_xlate`

## Requirements
- R1: After reset the page output is 0.
- R2: `bus_addr` always equals `{page, cmd_addr}`, with the page in bits 11:5 and the command address in bits 4:0.
- R3: A write strobe with `cmd_addr` = 31 loads `cmd_wdata[6:0]` into the page at the next rising clock. This works from every page, including unpopulated ones.
- R4: The page register is write-only. A read with `cmd_addr` = 31 asserts no `bus_rd` and returns `cmd_rdata` = 0.
- R5: A write with `cmd_addr` = 31 never asserts `bus_wr`.
- R6: A write to slots 0 to 30 on a populated page (page < `USED_PAGES`) asserts `bus_wr` in the same cycle. In that cycle `bus_wdata` equals `cmd_wdata`.
- R7: On an unpopulated page (page >= `USED_PAGES`), writes and reads to slots 0 to 30 assert neither `bus_wr` nor `bus_rd`, and `cmd_rdata` is 0.
- R8: A read of slots 0 to 30 on a populated page asserts `bus_rd` and returns `bus_rdata` on `cmd_rdata` in the same cycle.
- R9: The page keeps its value on every clock without a write to slot 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_addr | input | 5 | Register slot from the command |
| cmd_wr | input | 1 | Write strobe, one access per cycle |
| cmd_rd | input | 1 | Read strobe |
| cmd_wdata | input | 24 | Write data |
| cmd_rdata | output | 24 | Read data returned to the command side |
| bus_addr | output | 12 | Composed internal address |
| bus_wr | output | 1 | Register file write enable |
| bus_rd | output | 1 | Register file read enable |
| bus_wdata | output | 24 | Write data toward the register file |
| bus_rdata | input | 24 | Read data from the register file |
| page | output | 7 | Current page |

## Verification
The hardest case to reach is a page-register write issued while an unpopulated page is selected. It is the only way back to live registers, and every other access on that page is silently dropped. The random stimulus writes slot 31 often and loads page values drawn from a range twice as wide as the populated set, so runs regularly strand themselves on empty pages and then recover. Directed steps also load page 127, and load a value with high data bits set, so that truncation to 7 bits is observed.

// File: rtl/paged_reg_xlate.sv
module paged_reg_xlate #(
  parameter int CMD_AW     = 5,
  parameter int PAGE_W     = 7,
  parameter int DATA_W     = 24,
  parameter int USED_PAGES = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [CMD_AW-1:0]          cmd_addr,
  input  logic                       cmd_wr,
  input  logic                       cmd_rd,
  input  logic [DATA_W-1:0]          cmd_wdata,
  output logic [DATA_W-1:0]          cmd_rdata,
  output logic [PAGE_W+CMD_AW-1:0]   bus_addr,
  output logic                       bus_wr,
  output logic                       bus_rd,
  output logic [DATA_W-1:0]          bus_wdata,
  input  logic [DATA_W-1:0]          bus_rdata,
  output logic [PAGE_W-1:0]          page
);

  localparam logic [CMD_AW-1:0] SLOT     = '1;
  localparam bit                ALL_USED = USED_PAGES >= (1 << PAGE_W);
  localparam logic [PAGE_W-1:0] PAGE_LIM = PAGE_W'(USED_PAGES);

  logic hit_slot, page_ok;

  assign hit_slot = (cmd_addr == SLOT);
  assign page_ok  = ALL_USED || (page < PAGE_LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      page <= '0;
    else if (cmd_wr && hit_slot)
      page <= cmd_wdata[PAGE_W-1:0];
  end

  assign bus_addr  = {page, cmd_addr};
  assign bus_wr    = cmd_wr && !hit_slot && page_ok;
  assign bus_rd    = cmd_rd && !hit_slot && page_ok;
  assign bus_wdata = cmd_wdata;
  assign cmd_rdata = bus_rd ? bus_rdata : '0;

  // R1
  p_page_reset_r1: assert property (@(posedge clk)
    (rst_n && !$past(rst_n)) |-> (page == '0));

  p_page_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_addr == SLOT) |=> (page == $past(cmd_wdata[PAGE_W-1:0])));

  p_page_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_wr && cmd_addr == SLOT) |=> $stable(page));

  // R4 and R5
  p_slot_private_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_addr == SLOT) |-> (!bus_wr && !bus_rd && cmd_rdata == '0));

  p_unpop_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ALL_USED && page >= PAGE_LIM) |-> (!bus_wr && !bus_rd && cmd_rdata == '0));

  p_wr_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_addr != SLOT && (ALL_USED || page < PAGE_LIM)) |-> (bus_wr && bus_wdata == cmd_wdata));

  p_rd_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rd && cmd_addr != SLOT && (ALL_USED || page < PAGE_LIM)) |-> (bus_rd && cmd_rdata == bus_rdata));

endmodule

// File: tb/paged_reg_xlate_tb.sv
module paged_reg_xlate_tb_top;
  localparam int CLK_P = 10;
  localparam int USED  = 4;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [4:0]  cmd_addr = '0;
  logic        cmd_wr = 0, cmd_rd = 0;
  logic [23:0] cmd_wdata = '0;
  logic [23:0] cmd_rdata;
  logic [11:0] bus_addr;
  logic        bus_wr, bus_rd;
  logic [23:0] bus_wdata, bus_rdata;
  logic [6:0]  page;

  int n_run = 0, n_fail = 0;
  logic [6:0]  page_m;
  logic [23:0] model_mem [USED*32];
  logic [23:0] stub      [USED*32];

  always #(CLK_P/2) clk = ~clk;

  paged_reg_xlate #(.USED_PAGES(USED)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_addr(cmd_addr), .cmd_wr(cmd_wr), .cmd_rd(cmd_rd),
    .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .page(page));

  always_ff @(posedge clk) if (bus_wr) stub[bus_addr[6:0]] <= bus_wdata;
  assign bus_rdata = stub[bus_addr[6:0]];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit populated(input logic [6:0] p);
    return int'(p) < USED;
  endfunction

  task automatic do_op(input logic [4:0] a, input bit w, input bit r, input logic [23:0] d);
    bit slot, pop;
    logic [23:0] exp_rd;
    int idx;
    @(negedge clk);
    cmd_addr = a; cmd_wr = w; cmd_rd = r; cmd_wdata = d;
    #2;
    slot = (a == 5'd31);
    pop  = populated(page_m);
    idx  = int'(page_m) * 32 + int'(a);
    chk(bus_addr == {page_m, a}, "R2", 32'(bus_addr), 32'({page_m, a}));
    chk(bus_wr == (w && !slot && pop), slot ? "R5" : (pop ? "R6" : "R7"), 32'(bus_wr), 32'(w && !slot && pop));
    chk(bus_rd == (r && !slot && pop), slot ? "R4" : (pop ? "R8" : "R7"), 32'(bus_rd), 32'(r && !slot && pop));
    exp_rd = (r && !slot && pop) ? model_mem[idx] : 24'd0;
    chk(cmd_rdata == exp_rd, slot ? "R4" : (pop ? "R8" : "R7"), 32'(cmd_rdata), 32'(exp_rd));
    if (w && !slot && pop) chk(bus_wdata == d, "R6", 32'(bus_wdata), 32'(d));
    @(posedge clk);
    #1;
    if (w && slot) page_m = d[6:0];
    else if (w && pop) model_mem[idx] = d;
    chk(page == page_m, (w && slot) ? "R3" : "R9", 32'(page), 32'(page_m));
    cmd_wr = 0; cmd_rd = 0;
  endtask

  task automatic finish_run;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++; n_run++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < USED*32; i++) begin
      model_mem[i] = '0;
      stub[i] = '0;
    end
    page_m = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(page == 7'd0, "R1", 32'(page), 0);
    @(negedge clk);
    rst_n = 1;
    @(posedge clk); #1;
    chk(page == 7'd0, "R1", 32'(page), 0);

    do_op(5'd3, 1, 0, 24'hABCDEF);           // R6
    do_op(5'd3, 0, 1, 24'h0);                // R8
    do_op(5'd31, 0, 1, 24'h0);               // R4
    do_op(5'd31, 1, 0, 24'hFFFF85);          // R3 truncation to 0x05
    do_op(5'd3, 1, 0, 24'h123456);           // R7 dropped
    do_op(5'd3, 0, 1, 24'h0);                // R7
    do_op(5'd31, 1, 0, 24'h000002);          // R3 from unpopulated page
    do_op(5'd30, 1, 1, 24'h0F0F0F);          // R6 R8
    do_op(5'd30, 0, 1, 24'h0);               // R8
    do_op(5'd31, 1, 0, 24'h00007F);          // R3 top page
    do_op(5'd0, 1, 0, 24'h111111);           // R7
    do_op(5'd31, 1, 0, 24'h000000);          // R3 back to 0
    do_op(5'd3, 0, 1, 24'h0);                // R8 data kept

    for (int i = 0; i < 4000; i++) begin
      logic [4:0]  a;
      logic [23:0] d;
      a = ($urandom % 6 == 0) ? 5'd31 : 5'($urandom);
      d = 24'($urandom);
      if (a == 5'd31) d[6:0] = 7'($urandom % (2*USED));
      do_op(a, 1'($urandom), 1'($urandom), d);
    end
    finish_run();
  end
endmodule